// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM. Reads and writes can alternate on every clock, and no idle cycle is needed between them. Address, command, byte-strobe and chip-select inputs are registered on the rising clock edge. Read data comes straight out of the array and the forwarding path in the cycle that follows the address edge, with no output register. Write data is presented one cycle after its address. It is captured into a pending-write register and committed to the array on the next enabled edge. A read that hits the pending word in that window returns the new bytes merged over the old ones.

A 2-bit burst counter can replace the two low address bits of a burst, in either linear or interleaved order. A clock-enable input freezes all state. Three chip selects, an asynchronous output enable and a sleep input control whether operations start and whether the outputs drive. Each byte lane is 9 bits wide, parity included, and has its own active-low write strobe.

Top module: `zt_flow_sram`

## Requirements
- R1: A read loaded on a rising edge presents the addressed word on dq_o, with dq_oe_o high, during the cycle that directly follows that edge.
- R2: Writes and reads may be issued on consecutive edges with no idle cycle. The data of a write is the dq_i value sampled on the next enabled edge after its address edge.
- R3: A write updates only the lanes whose bw_ni bit is 0. Lane l is dq bits [9l+8:9l], and its top bit is that lane's parity bit. A write with bw_ni all ones leaves the word unchanged.
- R4: A read issued on the edge that captures a prior write's data, to the same address, returns the written lanes of the new data and the old contents in the other lanes.
- R5: While cen_ni is 1, no input is sampled, no write data is captured and all state is held. dq_o therefore stays unchanged as long as oe_ni and sleep_i do not change.
- R6: A load (adv_i=0) starts an operation only when ce1_ni=0, ce2_i=1 and ce3_ni=0. Any other load is a deselect, and dq_oe_o is 0 in the following cycle.
- R7: oe_ni=1 forces dq_oe_o to 0 combinationally, with no clock edge needed. Whenever dq_oe_o is 0, dq_o is 0.
- R8: dq_oe_o is 0 during the data cycle of every write.
- R9: adv_i=1 continues the burst by incrementing a 2-bit count n, and the low address bits become an offset. The offset is start+n mod 4 when mode_i was 0 at the load edge, and start XOR n when mode_i was 1.
- R10: A continuation keeps the read or write direction of the burst's load cycle, and ignores we_ni and the chip selects. A continuation after a deselect or while asleep is itself a deselect.
- R11: While sleep_i is 1, no operation starts, any burst ends and dq_oe_o is 0. The array contents are kept.
- R12: After rst_ni is released, no operation is active and dq_oe_o and dq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of control state |
| cen_ni | input | 1 | Clock enable, active low; high holds all state |
| addr_i | input | ADDR_W | Word address for load cycles |
| adv_i | input | 1 | 1 = advance the burst, 0 = load a new address |
| we_ni | input | 1 | Write enable on load cycles, active low |
| bw_ni | input | LANES | Per-lane write strobes, active low |
| ce1_ni | input | 1 | Chip select, active low |
| ce2_i | input | 1 | Chip select, active high |
| ce3_ni | input | 1 | Chip select, active low |
| mode_i | input | 1 | Burst order sampled at load: 0 linear, 1 interleaved |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep: blocks new operations, outputs off |
| dq_i | input | LANES*9 | Write data |
| dq_o | output | LANES*9 | Read data, zero when not driven |
| dq_oe_o | output | 1 | Output driver enable |

## Verification
On every cycle the assertions check these port-level rules: the output enable drops after a deselect, after a write load and under sleep or oe_ni; dq_o is zero whenever it is not driven; and dq_o is held while the clock is suspended. The scenarios alone can show that the data itself is right. This covers lane-masked writes, merged forwarding of a pending write, writes that a stall or sleep must not commit, and the exact address order of linear and interleaved bursts, both read and write, against an independent word model.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  typedef enum logic {
    BURST_LINEAR     = 1'b0,
    BURST_INTERLEAVE = 1'b1
  } burst_mode_e;

  function automatic logic [1:0] burst_offset(input logic [1:0]   start,
                                              input logic [1:0]   cnt,
                                              input burst_mode_e  mode);
    return (mode == BURST_INTERLEAVE) ? (start ^ cnt) : (start + cnt);
  endfunction

endpackage

// File: rtl/zt_burst_ctr.sv
module zt_burst_ctr
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  burst_mode_e       mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      mode_q <= BURST_LINEAR;
    end else if (en_i) begin
      if (load_i) begin
        base_q <= addr_i;
        cnt_q  <= '0;
        mode_q <= burst_mode_e'(mode_i);
      end else if (step_i) begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  assign addr_o = {base_q[ADDR_W-1:2], burst_offset(base_q[1:0], cnt_q, mode_q)};

endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int BYTE_W = 9,
  localparam int DEPTH  = 2 ** ADDR_W,
  localparam int DATA_W = LANES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [LANES-1:0]  wbe_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BYTE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && wbe_i[l]) mem_q[waddr_i] <= wdata_i[l*BYTE_W +: BYTE_W];
    end

    assign rdata_o[l*BYTE_W +: BYTE_W] = mem_q[raddr_i];
  end

endmodule

// File: rtl/zt_write_reg.sv
module zt_write_reg #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int BYTE_W = 9,
  localparam int DATA_W = LANES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LANES-1:0]  mem_be_o,
  output logic [DATA_W-1:0] mem_data_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic              pend_v_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [LANES-1:0]  pend_be_q;
  logic [DATA_W-1:0] pend_data_q;
  logic              hit;

  // one-deep late write: captured word is committed on the next enabled edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q    <= 1'b0;
      pend_addr_q <= '0;
      pend_be_q   <= '0;
      pend_data_q <= '0;
    end else if (en_i) begin
      pend_v_q <= cap_i;
      if (cap_i) begin
        pend_addr_q <= addr_i;
        pend_be_q   <= be_i;
        pend_data_q <= data_i;
      end
    end
  end

  assign mem_we_o   = en_i && pend_v_q;
  assign mem_addr_o = pend_addr_q;
  assign mem_be_o   = pend_be_q;
  assign mem_data_o = pend_data_q;

  assign hit = pend_v_q && (pend_addr_q == rd_addr_i);

  for (genvar l = 0; l < LANES; l++) begin : g_fwd
    assign rd_data_o[l*BYTE_W +: BYTE_W] = (hit && pend_be_q[l]) ?
                                           pend_data_q[l*BYTE_W +: BYTE_W] :
                                           arr_data_i[l*BYTE_W +: BYTE_W];
  end

endmodule

// File: rtl/zt_flow_sram.sv
module zt_flow_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int BYTE_W = 9,
  localparam int DATA_W = LANES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cen_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adv_i,
  input  logic              we_ni,
  input  logic [LANES-1:0]  bw_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic              mode_i,
  input  logic              oe_ni,
  input  logic              sleep_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);

  logic              en;
  logic              sel;
  logic              load_op;
  logic              adv_op;
  logic              op_start;
  logic              start_wr;

  logic              op_v_q;
  logic              op_wr_q;
  logic [LANES-1:0]  op_be_q;
  logic              burst_v_q;
  logic              burst_wr_q;

  logic [ADDR_W-1:0] cur_addr;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [LANES-1:0]  mem_be;
  logic [DATA_W-1:0] mem_data;
  logic [DATA_W-1:0] arr_data;
  logic [DATA_W-1:0] rd_data;

  assign en       = !cen_ni;
  assign sel      = !sleep_i && !ce1_ni && ce2_i && !ce3_ni;
  assign load_op  = !adv_i && sel;
  assign adv_op   = adv_i && burst_v_q && !sleep_i;
  assign op_start = load_op || adv_op;
  assign start_wr = adv_i ? burst_wr_q : !we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_v_q     <= 1'b0;
      op_wr_q    <= 1'b0;
      op_be_q    <= '0;
      burst_v_q  <= 1'b0;
      burst_wr_q <= 1'b0;
    end else if (en) begin
      op_v_q  <= op_start;
      op_wr_q <= op_start && start_wr;
      op_be_q <= ~bw_ni;
      if (!adv_i) begin
        burst_v_q <= sel;
        if (sel) burst_wr_q <= !we_ni;
      end else if (!adv_op) begin
        burst_v_q <= 1'b0;
      end
    end
  end

  zt_burst_ctr #(
    .ADDR_W (ADDR_W)
  ) i_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .load_i (load_op),
    .step_i (adv_op),
    .addr_i (addr_i),
    .mode_i (mode_i),
    .addr_o (cur_addr)
  );

  zt_write_reg #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .BYTE_W (BYTE_W)
  ) i_wreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .cap_i      (op_v_q && op_wr_q),
    .addr_i     (cur_addr),
    .be_i       (op_be_q),
    .data_i     (dq_i),
    .mem_we_o   (mem_we),
    .mem_addr_o (mem_addr),
    .mem_be_o   (mem_be),
    .mem_data_o (mem_data),
    .rd_addr_i  (cur_addr),
    .arr_data_i (arr_data),
    .rd_data_o  (rd_data)
  );

  zt_sram_array #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .BYTE_W (BYTE_W)
  ) i_array (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i (mem_addr),
    .wbe_i   (mem_be),
    .wdata_i (mem_data),
    .raddr_i (cur_addr),
    .rdata_o (arr_data)
  );

  assign dq_oe_o = op_v_q && !op_wr_q && !oe_ni && !sleep_i;
  assign dq_o    = dq_oe_o ? rd_data : '0;

endmodule

// File: rtl/zt_flow_sram_chk.sv
module zt_flow_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cen_ni,
  input logic              adv_i,
  input logic              we_ni,
  input logic              ce1_ni,
  input logic              ce2_i,
  input logic              ce3_ni,
  input logic              oe_ni,
  input logic              sleep_i,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_oe_o
);

  // R6
  desel_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && !adv_i && (ce1_ni || !ce2_i || ce3_ni)) |=> !dq_oe_o);

  // R8
  wr_data_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && !adv_i && !sleep_i && !ce1_ni && ce2_i && !ce3_ni && !we_ni) |=> !dq_oe_o);

  // R7
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dq_oe_o);

  // R7
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_o |-> (dq_o == '0));

  // R11
  sleep_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !dq_oe_o);

  // R5
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_ni |=> (!$stable(oe_ni) || !$stable(sleep_i) || $stable(dq_o)));

endmodule

bind zt_flow_sram zt_flow_sram_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cen_ni  (cen_ni),
  .adv_i   (adv_i),
  .we_ni   (we_ni),
  .ce1_ni  (ce1_ni),
  .ce2_i   (ce2_i),
  .ce3_ni  (ce3_ni),
  .oe_ni   (oe_ni),
  .sleep_i (sleep_i),
  .dq_o    (dq_o),
  .dq_oe_o (dq_oe_o)
);

// File: tb/test_zt_flow_sram.sv
module test_zt_flow_sram;

  localparam int CLK_P = 10;
  localparam int AW = 6;
  localparam int DW = 36;
  localparam logic [2:0] CE_ON  = 3'b010;
  localparam logic [2:0] CE_OFF = 3'b110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cen_n = 1'b0, adv = 1'b0, we_n = 1'b1, ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
  logic mode = 1'b0, oe_n = 1'b0, slp = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0] bw_n = 4'hf;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe;

  always #(CLK_P/2) clk = ~clk;

  zt_flow_sram #(.ADDR_W(AW), .LANES(4), .BYTE_W(9)) i_zt_flow_sram (
    .clk_i(clk), .rst_ni(rst_n), .cen_ni(cen_n), .addr_i(addr), .adv_i(adv),
    .we_ni(we_n), .bw_ni(bw_n), .ce1_ni(ce1_n), .ce2_i(ce2), .ce3_ni(ce3_n),
    .mode_i(mode), .oe_ni(oe_n), .sleep_i(slp), .dq_i(dq_in),
    .dq_o(dq_out), .dq_oe_o(dq_oe)
  );

  typedef struct {
    logic          oe;
    logic [DW-1:0] d;
    string         tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // word-level reference
  logic [DW-1:0] ref_mem [64];
  logic m_op_v = 0, m_op_wr = 0;
  logic [3:0] m_be = '0;
  logic [AW-1:0] m_addr = '0;
  logic b_v = 0, b_wr = 0, b_mode = 0;
  logic [AW-1:0] b_base = '0;
  logic [1:0] b_cnt = '0;

  function automatic logic [DW-1:0] pat(input logic [5:0] a);
    return {a, 3'b001, a ^ 6'h3f, 3'b010, a ^ 6'h2a, 3'b100, a ^ 6'h15, 3'b111};
  endfunction

  task automatic model_step(input string tag);
    logic st;
    logic [1:0] off;
    exp_t e;
    if (!cen_n) begin
      if (m_op_v && m_op_wr)
        for (int l = 0; l < 4; l++)
          if (m_be[l]) ref_mem[m_addr][l*9 +: 9] = dq_in[l*9 +: 9];
      st = 1'b0;
      if (!adv) begin
        if (!slp && !ce1_n && ce2 && !ce3_n) begin
          b_v = 1; b_wr = !we_n; b_base = addr; b_cnt = 0; b_mode = mode; st = 1;
        end else b_v = 0;
      end else if (b_v && !slp) begin
        b_cnt = b_cnt + 2'd1; st = 1;
      end else b_v = 0;
      off = b_mode ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt);
      m_op_v = st; m_op_wr = st && b_wr; m_be = ~bw_n;
      m_addr = {b_base[AW-1:2], off};
    end
    e.oe  = m_op_v && !m_op_wr && !oe_n && !slp;
    e.d   = e.oe ? ref_mem[m_addr] : '0;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic drive(input logic c_n, input logic a_dv, input logic [AW-1:0] a,
                       input logic w_n, input logic [2:0] ce, input logic [3:0] b_n,
                       input logic [DW-1:0] d, input logic o_n, input logic s,
                       input logic md, input string tag);
    @(negedge clk);
    cen_n = c_n; adv = a_dv; addr = a; we_n = w_n;
    {ce1_n, ce2, ce3_n} = ce; bw_n = b_n; dq_in = d; oe_n = o_n; slp = s; mode = md;
    model_step(tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [3:0] b_n, input logic [DW-1:0] d,
                    input string tag);
    drive(0, 0, a, 0, CE_ON, b_n, d, 0, 0, 0, tag);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    drive(0, 0, a, 1, CE_ON, 4'hf, d, 0, 0, 0, tag);
  endtask

  task automatic nop(input logic [DW-1:0] d, input string tag);
    drive(0, 0, '0, 1, CE_OFF, 4'hf, d, 0, 0, 0, tag);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor
  always @(posedge clk) begin
    exp_t e;
    #(CLK_P/4);
    if (sb.size() > 0) begin
      e = sb.pop_front();
      checks++;
      if (dq_oe !== e.oe || dq_out !== e.d) begin
        errors++;
        $display("FAIL %s: oe=%0b dq=%h expected oe=%0b dq=%h", e.tag, dq_oe, dq_out, e.oe, e.d);
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    checks++;
    if (dq_oe !== 1'b0 || dq_out !== '0) begin  // R12 reset state
      errors++;
      $display("FAIL R12: oe=%0b dq=%h expected oe=0 dq=0", dq_oe, dq_out);
    end
    @(negedge clk) rst_n = 1'b1;
    nop('0, "R12");

    // back-to-back writes fill the array
    for (int a = 0; a < 64; a++) wr(6'(a), 4'h0, (a == 0) ? '0 : pat(6'(a - 1)), "R2");
    nop(pat(6'd63), "R2");

    rd(6'd5, '0, "R1");
    rd(6'd40, '0, "R1");
    rd(6'd63, '0, "R1");

    // alternating write/read
    wr(6'd10, 4'h0, '0, "R2");
    rd(6'd11, 36'h1_2345_6789, "R2");
    wr(6'd12, 4'h0, '0, "R2");
    rd(6'd10, 36'h9_8765_4321, "R2");
    rd(6'd12, '0, "R2");

    // lane mask and forwarding
    wr(6'd20, 4'b1010, '0, "R3");
    rd(6'd20, 36'hF_FFFF_FFFF, "R4");
    rd(6'd20, '0, "R3");
    wr(6'd21, 4'hf, '0, "R3");
    rd(6'd21, 36'h0_0000_0000, "R3");
    wr(6'd22, 4'b0111, '0, "R3");
    wr(6'd22, 4'b1110, 36'hA_BCDE_F012, "R4");
    rd(6'd22, 36'h3_3333_3333, "R4");

    // clock suspend
    wr(6'd30, 4'h0, '0, "R5");
    drive(1, 0, 6'd31, 1, CE_ON, 4'h0, 36'hB_AD00_0BAD, 0, 0, 0, "R5");
    drive(1, 0, 6'd32, 0, CE_OFF, 4'h0, 36'hB_AD11_1BAD, 0, 0, 0, "R5");
    rd(6'd30, 36'h5_A5A5_A5A5, "R5");
    rd(6'd31, '0, "R5");
    drive(1, 0, 6'd0, 0, CE_ON, 4'h0, 36'hF_0F0F_0F0F, 0, 0, 0, "R5");
    drive(1, 1, 6'd0, 0, CE_ON, 4'h0, 36'hF_0F0F_0F0F, 0, 0, 0, "R5");
    rd(6'd31, '0, "R5");

    // chip selects
    rd(6'd5, '0, "R6");
    drive(0, 0, 6'd5, 1, 3'b110, 4'hf, '0, 0, 0, 0, "R6");
    rd(6'd5, '0, "R6");
    drive(0, 0, 6'd5, 1, 3'b000, 4'hf, '0, 0, 0, 0, "R6");
    rd(6'd5, '0, "R6");
    drive(0, 0, 6'd5, 1, 3'b011, 4'hf, '0, 0, 0, 0, "R6");

    // output enable
    drive(0, 0, 6'd6, 1, CE_ON, 4'hf, '0, 1, 0, 0, "R7");
    drive(1, 0, 6'd6, 1, CE_ON, 4'hf, '0, 0, 0, 0, "R7");
    drive(1, 0, 6'd6, 1, CE_ON, 4'hf, '0, 1, 0, 0, "R7");

    // write data cycle keeps outputs off even with oe active
    wr(6'd7, 4'h0, '0, "R8");
    rd(6'd7, 36'h7_7777_7777, "R8");

    // linear burst read from offset 2
    drive(0, 0, 6'h12, 1, CE_ON, 4'hf, '0, 0, 0, 0, "R9");
    for (int i = 0; i < 4; i++) drive(0, 1, 6'h00, 0, CE_OFF, 4'hf, '0, 0, 0, 0, "R9");
    // interleaved burst read from offset 3
    drive(0, 0, 6'h27, 1, CE_ON, 4'hf, '0, 0, 0, 1, "R9");
    for (int i = 0; i < 3; i++) drive(0, 1, 6'h00, 1, CE_ON, 4'hf, '0, 0, 0, 0, "R9");
    // interleaved burst from offset 1
    drive(0, 0, 6'h09, 1, CE_ON, 4'hf, '0, 0, 0, 1, "R9");
    for (int i = 0; i < 3; i++) drive(0, 1, 6'h00, 1, CE_ON, 4'hf, '0, 0, 0, 0, "R9");

    // burst write: direction kept, we_ni and selects ignored
    drive(0, 0, 6'h31, 0, CE_ON, 4'h0, '0, 0, 0, 0, "R10");
    drive(0, 1, 6'h00, 1, CE_OFF, 4'h0, 36'h1_1111_1111, 0, 0, 0, "R10");
    drive(0, 1, 6'h00, 1, CE_OFF, 4'b1100, 36'h2_2222_2222, 0, 0, 0, "R10");
    drive(0, 1, 6'h00, 1, CE_ON, 4'h0, 36'h3_3333_3333, 0, 0, 0, "R10");
    drive(0, 0, 6'h30, 1, CE_ON, 4'hf, 36'h4_4444_4444, 0, 0, 0, "R10");
    for (int i = 0; i < 3; i++) drive(0, 1, 6'h00, 0, CE_ON, 4'h0, '0, 0, 0, 0, "R10");
    // continuation after deselect
    nop('0, "R10");
    drive(0, 1, 6'h00, 1, CE_ON, 4'hf, '0, 0, 0, 0, "R10");
    drive(0, 1, 6'h00, 1, CE_ON, 4'hf, '0, 0, 0, 0, "R10");

    // sleep
    drive(0, 0, 6'd3, 1, CE_ON, 4'hf, '0, 0, 1, 0, "R11");
    drive(0, 0, 6'd3, 0, CE_ON, 4'h0, '0, 0, 1, 0, "R11");
    drive(0, 0, 6'd4, 1, CE_ON, 4'hf, 36'hD_EAD0_BEEF, 0, 1, 0, "R11");
    rd(6'd3, 36'hC_0FFE_E000, "R11");
    drive(0, 0, 6'd8, 1, CE_ON, 4'hf, '0, 0, 0, 0, "R11");
    drive(0, 1, 6'd0, 1, CE_ON, 4'hf, '0, 0, 1, 0, "R11");
    drive(0, 1, 6'd0, 1, CE_ON, 4'hf, '0, 0, 0, 0, "R11");
    rd(6'd4, '0, "R11");
    nop('0, "R11");

    repeat (3) @(posedge clk);
    #(CLK_P/2);
    summary();
  end

endmodule